// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transceiver

This block is a full-duplex start/stop serial port. A single 8-bit mode word, loaded at run time, sets the number of data bits, the parity, the number of stop bits and how many clocks make up one bit time. The transmit half accepts a character into a one-entry holding buffer. It moves the character into a shift register when the line is free, then sends it with a low start bit, the data least significant bit first, an optional parity bit and one or two high stop bits.

The receive half watches the line through a synchronizer and waits for a fall after the line has been seen high. It then times its samples with a down-counter. For ratios above one, the counter is first preset to half a bit time so that the start bit is checked at its middle. After that it is reloaded with a full bit time, so every later sample also lands mid-bit. The assembled character is placed in a one-entry receive buffer together with its parity, framing and overrun flags.

On the host side, characters move on valid/ready streams. A transmit character is taken on a clock where `tx_valid` and `tx_ready` are both high. `tx_ready` is the buffer-empty indication, so a host that holds `tx_valid` simply waits; nothing is lost. The receive stream presents `rx_valid` until the host asserts `rx_ready`. The receiver cannot be stalled: a character that arrives while the buffer is still full replaces the old one and raises the overrun flag. The error flags are plain sticky outputs, cleared by a `stat_rd` pulse.

Top module: `async_xcvr`

## Requirements
- R1: After reset, `txd` is 1, `tx_ready` is 1, `rx_valid` is 0 and all three error flags are 0; the mode word resets to 8'h4E.
- R2: Mode bits [1:0] give the clocks per bit: 01 means 1, 10 means 16, 11 means 32 and 00 means 64. Every transmitted bit is held on `txd` for exactly that many clocks.
- R3: Mode bits [3:2] hold the data length minus 5. A transmitted frame is a 0 start bit followed by that many data bits, least significant bit first.
- R4: Mode bit 4 enables a parity bit sent after the data. Mode bit 5 set selects even parity, where the parity bit is the XOR of the data bits; clear selects odd parity, its inverse.
- R5: Mode bits [7:6] equal to 11 send two stop bits of value 1; any other value sends one stop bit.
- R6: `tx_ready` falls on the clock after a character is accepted. It rises again when that character enters the shift register. This happens one clock after the previous frame's last stop bit has ended, or one clock after acceptance if the line is idle; the new start bit begins at that same edge.
- R7: With the first rising edge at which `rxd` is low as edge 0, `rx_valid` is set at edge 2 + H + P*(L+Q+1). Here P is the clocks per bit, H is P/2 (0 when P is 1), L is the data length and Q is 1 when parity is enabled.
- R8: The received character is right-aligned on `rx_data`, with the bits above the data length forced to 0.
- R9: `err_parity` is set on the same edge that sets `rx_valid` when the received parity bit disagrees with the parity recomputed from the received data.
- R10: `err_frame` is set on the same edge that sets `rx_valid` when the line is 0 at the first stop-bit sample.
- R11: When a character completes while `rx_valid` is still set and `rx_ready` is low, `err_overrun` is set and `rx_data` takes the new character.
- R12: A `stat_rd` pulse clears all error flags on the following edge, and a flag raised on that same edge takes priority. The error flags never stop reception: the next good frame is received normally.
- R13: A clock with `rx_valid` and `rx_ready` both high empties the receive buffer, and `rx_valid` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the bit rate is this clock divided by the selected ratio |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load `cfg_wdata` into the mode word |
| cfg_wdata | input | 8 | New mode word |
| tx_valid | input | 1 | Host offers a transmit character |
| tx_ready | output | 1 | Transmit holding buffer empty |
| tx_data | input | 8 | Transmit character, right-aligned |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |
| rx_valid | output | 1 | Receive buffer full |
| rx_ready | input | 1 | Host takes the received character |
| rx_data | output | 8 | Received character, right-aligned |
| stat_rd | input | 1 | Status read strobe; clears the error flags |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |

## Verification
On the transmit side, a bench model updates on each rising edge. It holds its own queue of expected line levels for the frame being sent and its own holding-buffer state. Its predicted `txd` and `tx_ready` are compared at every falling edge, so a start bit that comes one clock early or late, or a bit held one clock too long, is caught in the cycle it happens. For each received frame, the bench computes the edge fixed by R7, which counts the two synchronizer stages, the half-bit preset and one full bit time per data, parity and stop bit. It checks `rx_valid` at the falling edge just before that edge and again just after it, where the data and all three flags are also compared. Buffer reads and status reads are checked at the first falling edge after the strobe.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int MAXLEN = 8;
  localparam int FRAMEW = MAXLEN + 4;   // start, data, parity, two stops
  localparam int CNTW   = 6;            // holds 63 = largest clocks-per-bit minus one
  localparam int NBW    = 4;            // holds the longest bit count of a frame

  typedef struct packed {
    logic [1:0] stops;
    logic       even;
    logic       par_en;
    logic [1:0] len;
    logic [1:0] ratio;
  } mode_t;

  function automatic logic [CNTW-1:0] clocks_m1(input logic [1:0] code);
    case (code)
      2'b01:   return 6'd0;
      2'b10:   return 6'd15;
      2'b11:   return 6'd31;
      default: return 6'd63;
    endcase
  endfunction

  function automatic logic parity_of(input logic [MAXLEN-1:0] d,
                                     input logic [NBW-1:0] n,
                                     input logic even);
    logic p;
    p = 1'b0;
    for (int i = 0; i < MAXLEN; i++)
      if (i < int'(n)) p = p ^ d[i];
    return even ? p : ~p;
  endfunction
endpackage

// File: rtl/xcvr_tx.sv
module xcvr_tx
  import xcvr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNTW-1:0]   rm1,
  input  logic [NBW-1:0]    nlen,
  input  logic              par_en,
  input  logic              even,
  input  logic              two_stop,
  input  logic              tx_valid,
  input  logic [MAXLEN-1:0] tx_data,
  output logic              tx_ready,
  output logic              txd
);
  logic              hold_full;
  logic [MAXLEN-1:0] hold_q;
  logic              busy;
  logic [FRAMEW-1:0] sh;
  logic [NBW-1:0]    left;
  logic [CNTW-1:0]   tick;
  logic [FRAMEW-1:0] frame;
  logic [NBW-1:0]    nbits;

  assign nbits = 4'd2 + nlen + {3'd0, par_en} + {3'd0, two_stop};

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < MAXLEN; i++)
      if (i < int'(nlen)) frame[i+1] = hold_q[i];
    if (par_en) frame[nlen + 4'd1] = parity_of(hold_q, nlen, even);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
      busy      <= 1'b0;
      sh        <= '1;
      left      <= '0;
      tick      <= '0;
    end else begin
      if (tx_valid && tx_ready) begin
        hold_full <= 1'b1;
        hold_q    <= tx_data;
      end
      if (busy) begin
        if (tick == '0) begin
          if (left == '0) begin
            busy <= 1'b0;
          end else begin
            sh   <= {1'b1, sh[FRAMEW-1:1]};
            left <= left - 4'd1;
            tick <= rm1;
          end
        end else begin
          tick <= tick - 6'd1;
        end
      end else if (hold_full) begin
        sh        <= frame;
        busy      <= 1'b1;
        left      <= nbits - 4'd1;
        tick      <= rm1;
        hold_full <= 1'b0;
      end
    end
  end

  assign tx_ready = !hold_full;
  assign txd      = sh[0];

  // R6: an accepted character occupies the holding buffer on the next cycle
  a_r6_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);
  // R3: every frame opens with a low start bit
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  // R6: a frame in flight is never cut short by a new load
  a_r6_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (tick != '0) |=> busy);
endmodule

// File: rtl/xcvr_rx.sv
module xcvr_rx
  import xcvr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNTW-1:0]   rm1,
  input  logic [NBW-1:0]    nlen,
  input  logic              par_en,
  input  logic              even,
  input  logic              x1,
  input  logic              rxd,
  input  logic              rx_ready,
  input  logic              stat_rd,
  output logic              rx_valid,
  output logic [MAXLEN-1:0] rx_data,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun
);
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_t;

  logic line;

  generate
    if (SYNC_STAGES > 1) begin : g_sync
      logic [SYNC_STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '1;
        else        q <= {q[SYNC_STAGES-2:0], rxd};
      assign line = q[SYNC_STAGES-1];
    end else begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= 1'b1;
        else        q <= rxd;
      assign line = q;
    end
  endgenerate

  rx_st_t            st;
  logic              armed;
  logic [CNTW-1:0]   cnt;
  logic [NBW-1:0]    idx;
  logic [MAXLEN+1:0] acc;
  logic [NBW-1:0]    nbody;
  logic [MAXLEN-1:0] dmask;
  logic              deliver;
  logic              par_bad;

  assign nbody   = nlen + {3'd0, par_en};
  assign deliver = (st == RX_BITS) && (cnt == '0) && (idx == nbody);
  assign par_bad = par_en && (acc[nlen] != parity_of(acc[MAXLEN-1:0], nlen, even));

  always_comb
    for (int i = 0; i < MAXLEN; i++) dmask[i] = (i < int'(nlen));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= RX_IDLE;
      armed       <= 1'b0;
      cnt         <= '0;
      idx         <= '0;
      acc         <= '0;
      rx_valid    <= 1'b0;
      rx_data     <= '0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      case (st)
        RX_IDLE: begin
          if (line) begin
            armed <= 1'b1;
          end else if (armed) begin
            armed <= 1'b0;
            idx   <= '0;
            cnt   <= x1 ? '0 : (rm1 >> 1);
            st    <= x1 ? RX_BITS : RX_START;
          end
        end
        RX_START: begin
          if (cnt != '0) begin
            cnt <= cnt - 6'd1;
          end else if (line) begin
            st <= RX_IDLE;
          end else begin
            st  <= RX_BITS;
            cnt <= rm1;
          end
        end
        RX_BITS: begin
          if (cnt != '0) begin
            cnt <= cnt - 6'd1;
          end else begin
            cnt <= rm1;
            if (idx == nbody) begin
              st <= RX_IDLE;
            end else begin
              acc[idx] <= line;
              idx      <= idx + 4'd1;
            end
          end
        end
        default: st <= RX_IDLE;
      endcase

      if (stat_rd) begin
        err_parity  <= 1'b0;
        err_frame   <= 1'b0;
        err_overrun <= 1'b0;
      end
      if (deliver) begin
        rx_valid <= 1'b1;
        rx_data  <= acc[MAXLEN-1:0] & dmask;
        if (par_bad)              err_parity  <= 1'b1;
        if (!line)                err_frame   <= 1'b1;
        if (rx_valid && !rx_ready) err_overrun <= 1'b1;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  // R13: a read with nothing arriving empties the buffer
  a_r13_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && !deliver |=> !rx_valid);
  // R11: completing into an unread buffer flags overrun
  a_r11_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    deliver && rx_valid && !rx_ready |=> err_overrun);
  // R9: a parity error appears together with a full buffer
  a_r9_parity_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_parity) |-> rx_valid);
  // R10: a framing error appears together with a full buffer
  a_r10_frame_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_frame) |-> rx_valid);
endmodule

// File: rtl/async_xcvr.sv
module async_xcvr
  import xcvr_pkg::*;
#(
  parameter logic [7:0] RESET_MODE  = 8'h4E,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  output logic       txd,
  input  logic       rxd,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  input  logic       stat_rd,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun
);
  mode_t           mode_q;
  logic [CNTW-1:0] rm1;
  logic [NBW-1:0]  nlen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      mode_q <= mode_t'(RESET_MODE);
    else if (cfg_we) mode_q <= mode_t'(cfg_wdata);

  assign rm1  = clocks_m1(mode_q.ratio);
  assign nlen = {2'b00, mode_q.len} + 4'd5;

  xcvr_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rm1      (rm1),
    .nlen     (nlen),
    .par_en   (mode_q.par_en),
    .even     (mode_q.even),
    .two_stop (mode_q.stops == 2'b11),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .txd      (txd)
  );

  xcvr_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .rm1         (rm1),
    .nlen        (nlen),
    .par_en      (mode_q.par_en),
    .even        (mode_q.even),
    .x1          (mode_q.ratio == 2'b01),
    .rxd         (rxd),
    .rx_ready    (rx_ready),
    .stat_rd     (stat_rd),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .err_overrun (err_overrun)
  );
endmodule

// File: tb/sim_async_xcvr.sv
module sim_async_xcvr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = '0;
  logic       txd;
  logic       rxd = 1'b1;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       stat_rd = 1'b0;
  logic       err_parity, err_frame, err_overrun;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] cur_mode = 8'h4E;

  always #4 clk = ~clk;   // 125 MHz

  async_xcvr u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .txd(txd),
    .rxd(rxd), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .stat_rd(stat_rd), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int per_of(input logic [7:0] m);
    case (m[1:0])
      2'b01:   return 1;
      2'b10:   return 16;
      2'b11:   return 32;
      default: return 64;
    endcase
  endfunction
  function automatic int len_of(input logic [7:0] m);
    return int'(m[3:2]) + 5;
  endfunction
  function automatic bit par_bit(input logic [7:0] d, input int ln, input bit ev);
    bit p = 1'b0;
    for (int i = 0; i < ln; i++) p = p ^ d[i];
    return ev ? p : ~p;
  endfunction

  // transmit reference model: holding buffer plus queue of line levels
  logic [7:0] m_mode = 8'h4E;
  bit         m_full = 1'b0;
  logic [7:0] m_hold = '0;
  bit         m_busy = 1'b0;
  int         m_idx = 0;
  int         m_tick = 0;
  bit         fr[$];
  bit         m_take, m_load;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_full = 0; m_busy = 0; m_idx = 0; m_tick = 0; m_mode = 8'h4E;
      fr.delete();
    end else begin
      m_take = tx_valid && !m_full;
      m_load = !m_busy && m_full;
      if (m_busy) begin
        if (m_tick == 0) begin
          if (m_idx == fr.size() - 1) m_busy = 0;
          else begin m_idx++; m_tick = per_of(m_mode) - 1; end
        end else m_tick--;
      end
      if (m_load) begin
        fr.delete();
        fr.push_back(1'b0);
        for (int i = 0; i < len_of(m_mode); i++) fr.push_back(m_hold[i]);
        if (m_mode[4]) fr.push_back(par_bit(m_hold, len_of(m_mode), m_mode[5]));
        fr.push_back(1'b1);
        if (m_mode[7:6] == 2'b11) fr.push_back(1'b1);
        m_busy = 1; m_idx = 0; m_tick = per_of(m_mode) - 1; m_full = 0;
      end
      if (m_take) begin m_full = 1; m_hold = tx_data; end
      if (cfg_we) m_mode = cfg_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2/R3/R4/R5 txd", int'(txd), m_busy ? int'(fr[m_idx]) : 1);
      chk("R6 tx_ready", int'(tx_ready), int'(!m_full));
    end
  end

  task automatic set_mode(input logic [7:0] m);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = m;
    @(negedge clk); cfg_we = 1'b0; cur_mode = m;
  endtask

  task automatic tx_send(input logic [7:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic tx_drain();
    @(negedge clk);
    while (m_busy || m_full) @(negedge clk);
  endtask

  task automatic rx_test(input logic [7:0] d, input bit flip_par, input bit bad_stop,
                         input bit pre_valid, input bit e_pe, input bit e_fe,
                         input bit e_oe, input string tag);
    int per, ln, half, dly;
    bit pen, p;
    logic [7:0] mask;
    per  = per_of(cur_mode);
    ln   = len_of(cur_mode);
    pen  = cur_mode[4];
    half = (per == 1) ? 0 : per / 2;
    dly  = 2 + half + per * (ln + int'(pen) + 1);
    p    = par_bit(d, ln, cur_mode[5]) ^ flip_par;
    mask = 8'((9'h100 >> (8 - ln)) - 9'd1);
    fork
      begin
        @(negedge clk); rxd = 1'b0;
        repeat (per) @(negedge clk);
        for (int i = 0; i < ln; i++) begin rxd = d[i]; repeat (per) @(negedge clk); end
        if (pen) begin rxd = p; repeat (per) @(negedge clk); end
        rxd = !bad_stop; repeat (per) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * per) @(negedge clk);
      end
      begin
        @(negedge clk);
        repeat (dly) @(posedge clk);
        @(negedge clk);
        chk({tag, " rx_valid before due edge (R7)"}, int'(rx_valid), int'(pre_valid));
        @(negedge clk);
        chk({tag, " rx_valid at due edge (R7)"}, int'(rx_valid), 1);
        chk({tag, " rx_data (R8)"}, int'(rx_data), int'(d & mask));
        chk({tag, " err_parity (R9)"}, int'(err_parity), int'(e_pe));
        chk({tag, " err_frame (R10)"}, int'(err_frame), int'(e_fe));
        chk({tag, " err_overrun (R11)"}, int'(err_overrun), int'(e_oe));
      end
    join
  endtask

  task automatic host_read();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
    chk("R13 rx_valid after read", int'(rx_valid), 0);
  endtask

  task automatic status_read();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    chk("R12 flags after status read", int'({err_parity, err_frame, err_overrun}), 0);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd", int'(txd), 1);
    chk("R1 tx_ready", int'(tx_ready), 1);
    chk("R1 rx_valid", int'(rx_valid), 0);
    chk("R1 flags", int'({err_parity, err_frame, err_overrun}), 0);

    // x16, 8 data, no parity, 1 stop; second write waits for the buffer (R6)
    tx_send(8'hA5);
    tx_send(8'h3C);
    tx_drain();
    rx_test(8'hC3, 0, 0, 0, 0, 0, 0, "R7 x16 8N1");
    host_read();

    // x1, 7 data, even parity, 2 stops (R4, R5)
    set_mode(8'hF9);
    tx_send(8'h55);
    tx_drain();
    rx_test(8'h2B, 0, 0, 0, 0, 0, 0, "R4 x1 7E2");
    host_read();

    // x32, 5 data, odd parity, 1 stop; corrupted parity (R2, R9)
    set_mode(8'h53);
    tx_send(8'h1F);
    tx_drain();
    rx_test(8'hF5, 1, 0, 0, 1, 0, 0, "R9 x32 5O1");
    status_read();
    host_read();

    // x64, 6 data, no parity, 1 stop; bad stop then a good frame (R10, R12)
    set_mode(8'h44);
    tx_send(8'h2A);
    tx_drain();
    rx_test(8'h3C, 0, 1, 0, 0, 1, 0, "R10 x64 6N1");
    status_read();
    host_read();
    rx_test(8'h0F, 0, 0, 0, 0, 0, 0, "R12 after error");
    host_read();

    // x1, 8 data, no parity, 1 stop; overrun (R11, R13)
    set_mode(8'h4D);
    tx_send(8'hC9);
    tx_send(8'h36);
    tx_drain();
    rx_test(8'h81, 0, 0, 0, 0, 0, 0, "R11 first");
    rx_test(8'h7E, 0, 0, 1, 0, 0, 1, "R11 second");
    status_read();
    host_read();
  endtask

  initial begin
    bit timed_out = 1'b0;
    fork
      run_all();
      begin repeat (150000) @(posedge clk); timed_out = 1'b1; end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, all requirements affected");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule